// File: doc/BRIEF.md
# Hidden Memory Window Guard

This block owns the 128 KiB legacy window at physical addresses 0xA0000 to 0xBFFFF. System RAM behind that window is reserved for the processor's management mode, and the display adapter's frame buffer sits at the same addresses. For every access, the block decides whether the access goes to that protected RAM or to the display adapter. Accesses outside the window are marked as not decoded.

The decision depends on three things: an 8-bit control register, the processor's management-mode flag, and whether the access is an instruction fetch or a data access. Firmware can do three things with the register:
- open the window to normal-mode software,
- shut it to data accesses, so that management code can still fetch from RAM while it reaches the frame buffer with data,
- freeze the register until the next reset.

The freeze closes the window for good. After it, normal-mode software cannot reopen the window or turn the protection off to plant code in the protected RAM.

Top module: `hwin_guard`

## Requirements
- R1: After reset, `cfg_rdata` reads 8'h02, `cfg_conflict` is 0 and `route_sel` is 2'b00.
- R2: Register bits are as follows:
  - bit 7 always reads 0;
  - bit 6 is the open control;
  - bit 5 is the data-shut control;
  - bit 4 is the freeze control;
  - bit 3 is the window enable;
  - bits 2:0 always read the constant 3'b010.
  A write with `cfg_we` high takes effect at the next rising clock edge.
- R3: An access whose address lies from 0xA0000 to 0xBFFFF inclusive is decoded. Any other address yields `route_sel` = 2'b00 (not decoded). `route_sel` is registered: it shows the decision for the access presented in the cycle before, made with the register contents of that cycle. The codes are 2'b01 for protected RAM and 2'b10 for the display adapter.
- R4: With the enable bit clear, every decoded access routes to the display adapter (2'b10), whatever the mode and access type.
- R5: With enable set, open set and data-shut clear, every decoded access routes to RAM (2'b01), in and out of management mode.
- R6: With enable set and open clear, a decoded access outside management mode routes to the display adapter.
- R7: In management mode with enable set and the window not opened:
  - with data-shut set, a fetch routes to RAM and a data access routes to the display adapter;
  - with data-shut clear, both kinds of access route to RAM.
- R8: Writing 1 to the freeze bit sets it. Later writes never clear it; only reset does.
- R9: While freeze is set, writes to the open and enable bits are ignored, and the open bit reads 0. A write that sets freeze stores open as 0 in the same write. Data-shut stays writable.
- R10: When open and data-shut are both stored as 1, `cfg_conflict` is 1 and routing behaves as if data-shut alone were set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| cfg_conflict | output | 1 | Open and data-shut both set |
| mgmt_mode | input | 1 | Processor is in management mode |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| route_sel | output | 2 | 00 not decoded, 01 RAM, 10 display adapter |

## Verification
A register write and a window access can fall in the same cycle. The access must then be routed by the register contents from before the write, and the new setting applies only from the next access. The bench drives a write of the open bit together with a normal-mode access to 0xA0000. It expects the display route for that access and the RAM route for the access that follows. The same collision is exercised with a freeze write that also carries the open bit: the write must leave open at 0, and the access in that cycle must still see the old setting.

// File: rtl/hwin_pkg.sv
package hwin_pkg;

  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_RAM  = 2'b01,
    RT_DISP = 2'b10
  } route_t;

  localparam int BIT_OPEN = 6;
  localparam int BIT_SHUT = 5;
  localparam int BIT_LOCK = 4;
  localparam int BIT_EN   = 3;
  localparam logic [2:0] ID_CODE = 3'b010;

  typedef struct packed {
    logic open;
    logic shut;
    logic lock;
    logic en;
  } ctl_t;

  // Routing priority: enable, effective open, mode/type.
  function automatic route_t pick_route(ctl_t c, logic hit, logic mgmt, logic fetch);
    logic open_eff;
    open_eff = c.open & ~c.shut;
    if (!hit)          return RT_NONE;
    if (!c.en)         return RT_DISP;
    if (open_eff)      return RT_RAM;
    if (!mgmt)         return RT_DISP;
    if (c.shut && !fetch) return RT_DISP;
    return RT_RAM;
  endfunction

  function automatic logic [7:0] pack_ctl(ctl_t c);
    logic [7:0] v;
    v = 8'h00;
    v[BIT_OPEN] = c.open;
    v[BIT_SHUT] = c.shut;
    v[BIT_LOCK] = c.lock;
    v[BIT_EN]   = c.en;
    v[2:0]      = ID_CODE;
    return v;
  endfunction

endpackage

// File: rtl/hwin_cfg_reg.sv
module hwin_cfg_reg
  import hwin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output ctl_t       ctl,
  output logic [7:0] rdata,
  output logic       conflict
);

  // Named events for the assertions
  logic locked_write;
  logic lock_request;
  assign locked_write = we & ctl.lock;
  assign lock_request = we & wdata[BIT_LOCK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (we) begin
      ctl.lock <= ctl.lock | wdata[BIT_LOCK];
      ctl.shut <= wdata[BIT_SHUT];
      if (!ctl.lock) begin
        ctl.en   <= wdata[BIT_EN];
        ctl.open <= wdata[BIT_OPEN] & ~wdata[BIT_LOCK];
      end
    end
  end

  assign rdata    = pack_ctl(ctl);
  assign conflict = ctl.open & ctl.shut;

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.lock |=> ctl.lock);

  assert_open_zero_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.lock |-> !ctl.open);

  assert_en_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked_write |=> $stable(ctl.en));

  assert_lock_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_request |=> (ctl.lock && !ctl.open));

endmodule

// File: rtl/hwin_decode.sv
module hwin_decode #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hA0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h20000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + WIN_SIZE - 1'b1;

  function automatic logic in_window(logic [ADDR_W-1:0] a);
    return (a >= WIN_BASE) && (a <= WIN_LAST);
  endfunction

  assign hit = in_window(addr);

endmodule

// File: rtl/hwin_route.sv
module hwin_route
  import hwin_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ctl_t   ctl,
  input  logic   hit,
  input  logic   mgmt,
  input  logic   fetch,
  output route_t route_q
);

  route_t route_d;
  assign route_d = pick_route(ctl, hit, mgmt, fetch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_q <= RT_NONE;
    else        route_q <= route_d;
  end

  assert_outside_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> route_q == RT_NONE);

  assert_disabled_disp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ctl.en) |=> route_q == RT_DISP);

  assert_open_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctl.en && ctl.open && !ctl.shut) |=> route_q == RT_RAM);

  assert_normal_disp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctl.en && !ctl.open && !mgmt) |=> route_q == RT_DISP);

  assert_mgmt_fetch_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctl.en && mgmt && fetch) |=> route_q == RT_RAM);

  assert_conflict_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctl.en && ctl.open && ctl.shut && mgmt && !fetch) |=> route_q == RT_DISP);

endmodule

// File: rtl/hwin_guard.sv
module hwin_guard
  import hwin_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'hA0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              cfg_conflict,
  input  logic              mgmt_mode,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_fetch,
  output logic [1:0]        route_sel
);

  ctl_t   ctl;
  logic   win_hit;
  route_t route_q;

  hwin_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .ctl      (ctl),
    .rdata    (cfg_rdata),
    .conflict (cfg_conflict)
  );

  hwin_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
  ) u_dec (
    .addr (acc_addr),
    .hit  (win_hit)
  );

  hwin_route u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .hit     (win_hit),
    .mgmt    (mgmt_mode),
    .fetch   (acc_fetch),
    .route_q (route_q)
  );

  assign route_sel = route_q;

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7] == 1'b0 && cfg_rdata[2:0] == 3'b010);

endmodule

// File: tb/test_hwin_guard.sv
module test_hwin_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        cfg_conflict;
  logic        mgmt_mode = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_fetch = 1'b0;
  logic [1:0]  route_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side register model
  bit m_open, m_shut, m_lock, m_en;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  hwin_guard i_hwin_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .cfg_conflict (cfg_conflict),
    .mgmt_mode    (mgmt_mode),
    .acc_addr     (acc_addr),
    .acc_fetch    (acc_fetch),
    .route_sel    (route_sel)
  );

  function automatic logic [1:0] model_route(logic [31:0] a, bit mm, bit f);
    bit inside_win;
    inside_win = (a >= 32'hA0000) && (a < 32'hC0000);
    case (1'b1)
      !inside_win:            return 2'b00;
      !m_en:                  return 2'b10;
      (m_open && !m_shut):    return 2'b01;
      !mm:                    return 2'b10;
      (m_shut && !f):         return 2'b10;
      default:                return 2'b01;
    endcase
  endfunction

  function automatic logic [7:0] model_reg();
    return {1'b0, m_open, m_shut, m_lock, m_en, 3'b010};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one access per cycle, optional write in the same cycle
  task automatic step(bit we, logic [7:0] wd, bit mm, logic [31:0] a, bit f, string tag);
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd; mgmt_mode = mm; acc_addr = a; acc_fetch = f;
    exp_q.push_back(model_route(a, mm, f));
    tag_q.push_back(tag);
    if (we) begin
      m_shut = wd[5];
      if (!m_lock) begin
        m_en   = wd[3];
        m_open = wd[6] && !wd[4];
      end
      m_lock = m_lock || wd[4];
    end
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic wr(logic [7:0] wd);
    step(1'b1, wd, 1'b0, 32'h0, 1'b0, "R3");
  endtask

  task automatic check_reg(string tag);
    @(negedge clk);
    check(tag, cfg_rdata, model_reg());
    check(tag, {7'b0, cfg_conflict}, {7'b0, m_open & m_shut});
  endtask

  // Monitor: compares registered route one edge after each access
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {6'b0, route_sel}, {6'b0, e});
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    m_open = 0; m_shut = 0; m_lock = 0; m_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    @(negedge clk);
    check("R1 rdata", cfg_rdata, 8'h02);
    check("R1 conflict", {7'b0, cfg_conflict}, 8'h00);
    check("R1 route", {6'b0, route_sel}, 8'h00);

    // R4: window disabled
    step(0, 0, 0, 32'hA0000, 0, "R4");
    step(0, 0, 1, 32'hBFFFF, 1, "R4");
    // R3: edges of the window
    step(0, 0, 0, 32'h9FFFF, 0, "R3");
    step(0, 0, 1, 32'hC0000, 1, "R3");

    // R2/R5: open + enable
    wr(8'h48);
    check_reg("R2 open+en");
    step(0, 0, 0, 32'hA0000, 0, "R5");
    step(0, 0, 1, 32'hB1234, 1, "R5");
    step(0, 0, 1, 32'hBFFFF, 0, "R5");

    // R10: open and shut both, reserved bit written
    wr(8'hE8);
    check_reg("R10 conflict");
    step(0, 0, 1, 32'hA8000, 0, "R10");
    step(0, 0, 1, 32'hA8000, 1, "R10");
    step(0, 0, 0, 32'hA8000, 1, "R10");

    // R6/R7: enable only
    wr(8'h0F);
    check_reg("R2 low field");
    step(0, 0, 0, 32'hA0000, 1, "R6");
    step(0, 0, 1, 32'hA0000, 0, "R7");
    step(0, 0, 1, 32'hA0000, 1, "R7");

    // R7: shut set
    wr(8'h28);
    step(0, 0, 1, 32'hB0000, 0, "R7");
    step(0, 0, 1, 32'hB0000, 1, "R7");

    // R3: write and access in the same cycle use the old setting
    wr(8'h08);
    step(1, 8'h48, 0, 32'hA0000, 0, "R3 same-cycle");
    step(0, 0, 0, 32'hA0000, 0, "R5 after write");

    // R9/R8: freeze with open in the same write, access colliding
    step(1, 8'h58, 0, 32'hA0000, 0, "R9 same-cycle");
    check_reg("R9 lock clears open");
    step(0, 0, 0, 32'hA0000, 0, "R9");
    wr(8'h40);
    check_reg("R8 lock sticky");
    step(0, 0, 0, 32'hA0000, 0, "R9 open ignored");
    wr(8'h20);
    check_reg("R9 shut writable");
    step(0, 0, 1, 32'hA0000, 0, "R9");
    step(0, 0, 1, 32'hA0000, 1, "R9");
    wr(8'h00);
    check_reg("R9 enable kept");

    // R8: only reset clears the freeze
    @(negedge clk);
    do_reset();
    @(negedge clk);
    check("R8 reset clears lock", cfg_rdata, 8'h02);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule